// File: doc/BRIEF.md
# FIFO-Buffered Streaming Multiplier

The block is a memory-mapped accelerator for unsigned multiplication. Software packs two 16-bit operands into one 32-bit word and writes it to the job queue. It can queue several jobs before it reads any result. A small control stage takes jobs from the head of the job queue, multiplies the operands in one registered stage, and places each 32-bit product in a result queue. Software drains the result queue at its own pace. Results always leave in the same order as the jobs went in.

The bus port is a plain register-style port with a word address. Address 0 is the data port: a write pushes a job and a read pops a result. Address 1 returns the status word. Address 2 is a write-only control word that empties either queue. The job queue and the result queue each have a separate reset. The control stage stops taking jobs when the result queue could not accept the product, so no product is ever lost.

Top module: `mulq_top`

## Requirements
- R1: A job word carries operand A in bits [15:0] and operand B in bits [31:16]. The result read back is the 32-bit unsigned product A*B.
- R2: Results are read back from the data port (address 0) in the order their jobs were written.
- R3: With both queues empty, a job written at clock edge k is held in the multiply register after edge k+1 and enters the result queue at edge k+2. A status read at edge k+1 returns 0x04, at edge k+2 returns 0x05 and at edge k+3 returns 0x01.
- R4: A job is taken from the job queue only when the free space in the result queue is greater than the number of products in flight. While the result queue is full, further jobs stay queued and none is lost.
- R5: A data-port write while the job queue is full is discarded and sets the sticky overflow flag (status bit 4).
- R6: A data-port read while the result queue is empty returns 0 and sets the sticky underflow flag (status bit 5).
- R7: A read of address 1 returns the status word: bit0 job queue empty, bit1 job queue full, bit2 result queue empty, bit3 result queue full, bit4 overflow, bit5 underflow, and zeros above. The read clears both sticky flags unless the same edge sets them again.
- R8: Writing address 2 with bit0 set empties the job queue. Jobs that were queued never produce results, and results already in the result queue are kept.
- R9: Writing address 2 with bit1 set empties the result queue and cancels a product held in the multiply register. No stale result appears afterwards, and later jobs work normally.
- R10: After synchronous active-low reset both queues are empty, the sticky flags are clear and the read data is 0, so the status word reads 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe, data valid after the edge |
| bus_addr | input | 2 | Word address: 0 data, 1 status, 2 control |
| bus_wdata | input | 32 | Write data: job word or control word |
| bus_rdata | output | 32 | Registered read data, held between reads |

## Verification
The bench builds the block with both queues four entries deep and keeps the 16-bit operand width. At that depth the result queue fills after four jobs, and the job queue fills behind it after four more. This brings backpressure, overflow on a full job queue, and a job-queue reset that discards jobs stalled behind a full result queue within a few dozen cycles. It also places a result-queue reset on the exact cycle a product sits in the multiply register, so the cancel path is exercised, and it multiplies all-ones operands to cover the top of the product range.

// File: rtl/mulq_pkg.sv
// Shared definitions for the streaming multiplier: bus word addresses,
// control bits and status bit positions.
package mulq_pkg;

    // Word addresses on the register-style bus port
    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CTRL = 2'd2
    } mulq_addr_e;

    // Control word bits (address 2)
    localparam int CTRL_JOB_CLR = 0;
    localparam int CTRL_RES_CLR = 1;

    // Status word bit positions (address 1)
    localparam int ST_JOB_EMPTY = 0;
    localparam int ST_JOB_FULL  = 1;
    localparam int ST_RES_EMPTY = 2;
    localparam int ST_RES_FULL  = 3;
    localparam int ST_OVF       = 4;
    localparam int ST_UDF       = 5;
    localparam int ST_BITS      = 6;

endpackage

// File: rtl/mulq_fifo.sv
// Synchronous single-clock FIFO with a combinational head output.
// Assumes DEPTH >= 2. A push while full and a pop while empty are ignored.
// A synchronous clear empties the queue and overrides push and pop.
module mulq_fifo #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_mod
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    // Storage write; contents need no reset because the count guards reads
    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign count = cnt;

endmodule

// File: rtl/mulq_mul_stage.sv
// One registered unsigned multiply stage with a valid bit that tracks the job.
// A flush clears the valid bit and takes priority over a load.
module mulq_mul_stage #(
    parameter  int OPW    = 16,
    localparam int PROD_W = 2 * OPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    output logic              prod_valid,
    output logic [PROD_W-1:0] prod
);
    // Capture the product and its valid bit on each edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_valid <= 1'b0;
            prod       <= '0;
        end else if (flush) begin
            prod_valid <= 1'b0;
        end else begin
            prod_valid <= load;
            if (load) begin
                prod <= PROD_W'(op_a) * PROD_W'(op_b);
            end
        end
    end

endmodule

// File: rtl/mulq_issue.sv
// Decides when a job leaves the job queue. Assumes one multiply stage, so
// at most one product is in flight. Issue stops during either queue clear.
module mulq_issue #(
    parameter  int RES_DEPTH = 16,
    localparam int CNT_W     = $clog2(RES_DEPTH + 1)
) (
    input  logic             job_empty,
    input  logic             job_clr,
    input  logic             res_clr,
    input  logic             stage_valid,
    input  logic [CNT_W-1:0] res_count,
    output logic             job_pop
);
    logic [CNT_W-1:0] res_free;

    // Free result slots must exceed the products already in flight
    always_comb begin
        res_free = CNT_W'(RES_DEPTH) - res_count;
        job_pop  = !job_empty && !job_clr && !res_clr &&
                   (res_free > CNT_W'(stage_valid));
    end

endmodule

// File: rtl/mulq_regif.sv
// Bus decode for the multiplier: data push and pop, status word, control
// clears, sticky overflow and underflow flags, and the registered read data.
// Assumes at most one read and one write per cycle. A sticky set wins over
// a clear on the same edge.
module mulq_regif
    import mulq_pkg::*;
#(
    parameter  int OPW    = 16,
    localparam int DATA_W = 2 * OPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              job_full,
    input  logic              job_empty,
    input  logic              res_full,
    input  logic              res_empty,
    input  logic [DATA_W-1:0] res_head,
    output logic              job_push,
    output logic              res_pop,
    output logic              job_clr,
    output logic              res_clr,
    output logic              ovf_flag,
    output logic              udf_flag
);
    logic                wr_data, rd_data, rd_stat, wr_ctrl;
    logic                ovf_set, udf_set;
    logic [ST_BITS-1:0]  stat_bits;

    // Address decode of the bus strobes
    always_comb begin
        wr_data = bus_wr_en && (bus_addr == ADDR_DATA);
        wr_ctrl = bus_wr_en && (bus_addr == ADDR_CTRL);
        rd_data = bus_rd_en && (bus_addr == ADDR_DATA);
        rd_stat = bus_rd_en && (bus_addr == ADDR_STAT);
        job_push = wr_data && !job_full;
        ovf_set  = wr_data && job_full;
        res_pop  = rd_data && !res_empty;
        udf_set  = rd_data && res_empty;
        job_clr  = wr_ctrl && bus_wdata[CTRL_JOB_CLR];
        res_clr  = wr_ctrl && bus_wdata[CTRL_RES_CLR];
    end

    // Status word assembly
    always_comb begin
        stat_bits               = '0;
        stat_bits[ST_JOB_EMPTY] = job_empty;
        stat_bits[ST_JOB_FULL]  = job_full;
        stat_bits[ST_RES_EMPTY] = res_empty;
        stat_bits[ST_RES_FULL]  = res_full;
        stat_bits[ST_OVF]       = ovf_flag;
        stat_bits[ST_UDF]       = udf_flag;
    end

    // Sticky error flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_set || (ovf_flag && !rd_stat);
            udf_flag <= udf_set || (udf_flag && !rd_stat);
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_data) begin
            bus_rdata <= res_empty ? '0 : res_head;
        end else if (rd_stat) begin
            bus_rdata <= DATA_W'(stat_bits);
        end else if (bus_rd_en) begin
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/mulq_top.sv
// Streaming multiplier peripheral. The bus pushes packed operand pairs into
// a job queue. The issue stage pops a job into the registered multiplier
// only when the result queue has room, and valid products go to the result
// queue, which the bus pops. Each queue has its own clear.
module mulq_top #(
    parameter  int OPW       = 16,
    parameter  int JOB_DEPTH = 16,
    parameter  int RES_DEPTH = 16,
    localparam int DATA_W    = 2 * OPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int JCNT_W = $clog2(JOB_DEPTH + 1);
    localparam int RCNT_W = $clog2(RES_DEPTH + 1);

    logic              job_push, job_pop, job_clr, job_full, job_empty;
    logic [DATA_W-1:0] job_head;
    logic [JCNT_W-1:0] job_count;
    logic              res_push, res_pop, res_clr, res_full, res_empty;
    logic [DATA_W-1:0] res_head;
    logic [RCNT_W-1:0] res_count;
    logic              stage_valid;
    logic [DATA_W-1:0] stage_prod;
    logic              ovf_flag, udf_flag;

    mulq_regif #(.OPW(OPW)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .job_full  (job_full),
        .job_empty (job_empty),
        .res_full  (res_full),
        .res_empty (res_empty),
        .res_head  (res_head),
        .job_push  (job_push),
        .res_pop   (res_pop),
        .job_clr   (job_clr),
        .res_clr   (res_clr),
        .ovf_flag  (ovf_flag),
        .udf_flag  (udf_flag)
    );

    mulq_fifo #(.WIDTH(DATA_W), .DEPTH(JOB_DEPTH)) u_job_q (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (job_clr),
        .push  (job_push),
        .pop   (job_pop),
        .wdata (bus_wdata),
        .rdata (job_head),
        .full  (job_full),
        .empty (job_empty),
        .count (job_count)
    );

    mulq_issue #(.RES_DEPTH(RES_DEPTH)) u_issue (
        .job_empty   (job_empty),
        .job_clr     (job_clr),
        .res_clr     (res_clr),
        .stage_valid (stage_valid),
        .res_count   (res_count),
        .job_pop     (job_pop)
    );

    mulq_mul_stage #(.OPW(OPW)) u_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (res_clr),
        .load       (job_pop),
        .op_a       (job_head[OPW-1:0]),
        .op_b       (job_head[DATA_W-1:OPW]),
        .prod_valid (stage_valid),
        .prod       (stage_prod)
    );

    // Only a valid product that survives a result clear enters the queue
    assign res_push = stage_valid && !res_clr;

    mulq_fifo #(.WIDTH(DATA_W), .DEPTH(RES_DEPTH)) u_res_q (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (res_clr),
        .push  (res_push),
        .pop   (res_pop),
        .wdata (stage_prod),
        .rdata (res_head),
        .full  (res_full),
        .empty (res_empty),
        .count (res_count)
    );

endmodule

// File: rtl/mulq_chk.sv
// Assertion checker for mulq_top, attached with bind. It observes ports and
// signals that pass between the submodules.
module mulq_chk
    import mulq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int JOB_DEPTH = 16,
    parameter int JCNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              job_pop,
    input logic              job_empty,
    input logic              job_full,
    input logic [JCNT_W-1:0] job_count,
    input logic              job_clr,
    input logic              res_push,
    input logic              res_full,
    input logic              res_empty,
    input logic              res_clr,
    input logic              stage_valid,
    input logic              ovf_flag,
    input logic              udf_flag
);
    // R4
    res_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_push |-> !res_full);

    // R4
    job_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_pop |-> !job_empty);

    // R5
    job_depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_count <= JCNT_W'(JOB_DEPTH));

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_DATA && job_full) |=> ovf_flag);

    // R6
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_DATA && res_empty) |=> (bus_rdata == '0 && udf_flag));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_STAT && !bus_wr_en) |=> (!ovf_flag && !udf_flag));

    // R8
    job_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_clr |=> job_empty);

    // R9
    res_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_clr |=> (res_empty && !stage_valid));

endmodule

bind mulq_top mulq_chk #(
    .DATA_W    (DATA_W),
    .JOB_DEPTH (JOB_DEPTH),
    .JCNT_W    (JCNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_rd_en   (bus_rd_en),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .job_pop     (job_pop),
    .job_empty   (job_empty),
    .job_full    (job_full),
    .job_count   (job_count),
    .job_clr     (job_clr),
    .res_push    (res_push),
    .res_full    (res_full),
    .res_empty   (res_empty),
    .res_clr     (res_clr),
    .stage_valid (stage_valid),
    .ovf_flag    (ovf_flag),
    .udf_flag    (udf_flag)
);

// File: tb/mulq_top_tb_top.sv
// Bench for mulq_top: directed sequences with expected constants, plus a
// behavioural queue model compared against the read data on every clock.
module mulq_top_tb_top;
    localparam int OPW = 16;
    localparam int JD  = 4;
    localparam int RD  = 4;
    localparam int DW  = 2 * OPW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mulq_top #(.OPW(OPW), .JOB_DEPTH(JD), .RES_DEPTH(RD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Behavioural reference: queues and an in-flight slot
    logic [31:0] jq[$];
    logic [31:0] rq[$];
    bit          m_sv;
    logic [31:0] m_sd;
    bit          m_ovf, m_udf;
    logic [31:0] m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            jq.delete(); rq.delete();
            m_sv = 0; m_sd = 0; m_ovf = 0; m_udf = 0; m_rdata = 0;
        end else begin
            bit jclr, rclr, take, give, oset, uset, sclr;
            logic [31:0] head;
            logic [31:0] st;
            jclr = bus_wr_en && bus_addr == 2 && bus_wdata[0];
            rclr = bus_wr_en && bus_addr == 2 && bus_wdata[1];
            take = jq.size() > 0 && !jclr && !rclr && (RD - rq.size()) > int'(m_sv);
            give = m_sv && !rclr;
            oset = bus_wr_en && bus_addr == 0 && jq.size() == JD;
            uset = bus_rd_en && bus_addr == 0 && rq.size() == 0;
            sclr = bus_rd_en && bus_addr == 1;
            st = {26'd0, m_udf, m_ovf, rq.size() == RD, rq.size() == 0,
                  jq.size() == JD, jq.size() == 0};
            if (bus_rd_en) begin
                if (bus_addr == 0) m_rdata = (rq.size() > 0) ? rq.pop_front() : 32'd0;
                else if (bus_addr == 1) m_rdata = st;
                else m_rdata = 0;
            end
            if (give) rq.push_back(m_sd);
            head = (jq.size() > 0) ? jq[0] : 32'd0;
            if (take) void'(jq.pop_front());
            if (bus_wr_en && bus_addr == 0 && !oset) jq.push_back(bus_wdata);
            if (rclr) begin m_sv = 0; rq.delete(); end
            else begin
                m_sv = take;
                if (take) m_sd = 32'(head[15:0]) * 32'(head[31:16]);
            end
            if (jclr) jq.delete();
            m_ovf = oset || (m_ovf && !sclr);
            m_udf = uset || (m_udf && !sclr);
        end
    end

    // Continuous comparison of read data against the model (R2)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (bus_rdata !== m_rdata) begin
                n_errors++;
                $display("FAIL R2 model compare: rdata=%h expected=%h at %0t", bus_rdata, m_rdata, $time);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state
        check("R10 rdata after reset", bus_rdata, 32'h0);
        bus_rd(1, d); check("R10 status after reset", d, 32'h05);

        // R1 R2: packed example sequence
        for (int i = 1; i <= 4; i++) bus_wr(0, (i << 16) | i);
        idle(6);
        bus_rd(0, d); check("R2 first product", d, 32'h1);
        bus_rd(0, d); check("R2 second product", d, 32'h4);
        bus_rd(0, d); check("R2 third product", d, 32'h9);
        bus_rd(0, d); check("R2 fourth product", d, 32'h10);

        // R3: latency seen through status
        bus_wr(0, 32'h0005_0007);
        bus_rd(1, d); check("R3 status edge k+1", d, 32'h04);
        bus_rd(1, d); check("R3 status edge k+2", d, 32'h05);
        bus_rd(1, d); check("R3 status edge k+3", d, 32'h01);
        bus_rd(0, d); check("R3 latency product", d, 32'd35);

        // R1: operand placement and extreme values
        bus_wr(0, 32'hFFFF_0002);
        bus_wr(0, 32'hFFFF_FFFF);
        bus_wr(0, 32'h0000_1234);
        idle(5);
        bus_rd(0, d); check("R1 B=ffff A=2", d, 32'h0001_FFFE);
        bus_rd(0, d); check("R1 all ones", d, 32'hFFFE_0001);
        bus_rd(0, d); check("R1 zero operand B", d, 32'h0);

        // R4 R5 R7: backpressure, overflow, sticky clear
        for (int i = 0; i < 8; i++) bus_wr(0, ((i + 1) << 16) | (i + 3));
        idle(8);
        bus_rd(1, d); check("R4 both queues full", d, 32'h0A);
        bus_wr(0, 32'h0009_0009);
        bus_rd(1, d); check("R5 overflow flag set", d, 32'h1A);
        bus_rd(1, d); check("R7 overflow cleared by status read", d, 32'h0A);
        for (int i = 0; i < 4; i++) begin
            bus_rd(0, d); check("R4 held product order", d, (i + 1) * (i + 3));
        end
        idle(10);
        for (int i = 4; i < 8; i++) begin
            bus_rd(0, d); check("R4 stalled job product", d, (i + 1) * (i + 3));
        end
        bus_rd(1, d); check("R5 dropped job left no result", d, 32'h05);

        // R6 R7: underflow
        bus_rd(0, d); check("R6 empty read returns zero", d, 32'h0);
        bus_rd(1, d); check("R6 underflow flag set", d, 32'h25);
        bus_rd(1, d); check("R7 underflow cleared", d, 32'h05);

        // R8: job queue clear keeps results
        for (int i = 0; i < 4; i++) bus_wr(0, (32'd2 << 16) | (i + 1));
        idle(8);
        bus_wr(0, 32'h0007_0007);
        bus_wr(0, 32'h0008_0008);
        idle(3);
        bus_rd(1, d); check("R8 jobs waiting behind full results", d, 32'h08);
        bus_wr(2, 32'h1);
        bus_rd(1, d); check("R8 job queue emptied", d, 32'h09);
        for (int i = 0; i < 4; i++) begin
            bus_rd(0, d); check("R8 results kept", d, 2 * (i + 1));
        end
        idle(6);
        bus_rd(0, d); check("R8 cleared jobs gave no result", d, 32'h0);
        bus_rd(1, d); check("R8 status after clear", d, 32'h25);

        // R9: result queue clear cancels the in-flight product
        bus_wr(0, 32'h0003_0003);
        bus_wr(0, 32'h0004_0004);
        idle(6);
        bus_wr(0, 32'h0006_0006);
        idle(1);
        bus_wr(2, 32'h2);
        idle(5);
        bus_rd(1, d); check("R9 both empty after result clear", d, 32'h05);
        bus_rd(0, d); check("R9 no stale product", d, 32'h0);
        bus_rd(1, d); check("R9 underflow after clear", d, 32'h25);
        bus_wr(0, 32'h0003_0004);
        idle(4);
        bus_rd(0, d); check("R9 job after clear works", d, 32'd12);

        idle(3);
        finish_run();
    end

endmodule